// File: doc/BRIEF.md
# USB bus reset detector

This block watches the two USB data line inputs of a device port and recognises a bus reset. A bus reset is a single-ended zero (SE0, both lines low) that lasts longer than a fixed threshold. The lines are asynchronous to the local clock, so both pass through a synchronizer. A counter then measures how long the synchronized SE0 condition holds without a break. When the run reaches the threshold, the block raises a single-cycle event.

A configuration input routes that event either to a chip reset request or to an interrupt request. A module enable input switches detection off entirely. A sticky flag records that a bus reset was seen, and a write-one-to-clear strobe clears it. When the lines leave SE0 after a detected bus reset, the block emits a one-cycle pulse. The address logic uses that pulse to return the device to the attached, unaddressed state. Enumeration itself is handled elsewhere.

Top module: `usb_bus_reset_det`

## Requirements
- R1: The line encoding is SE0 = (dp_i=0, dn_i=0). A bus reset is detected when SE0 is sampled on SE0_CYCLES+1 consecutive rising edges. The routed output pulses exactly SYNC_STAGES+SE0_CYCLES+1 edges after the first such edge.
- R2: A run of SE0 shorter than SE0_CYCLES+1 samples produces no event. Any non-SE0 sample (J = 1/0, K = 0/1, SE1 = 1/1) restarts the count from zero.
- R3: With route_irq_i=0 the event appears on chip_rst_req_o, and with route_irq_i=1 it appears on irq_o. The two outputs are never high together.
- R4: Each event is a one-cycle pulse issued once per SE0 episode, however long the episode lasts. The detector re-arms only after the lines leave SE0.
- R5: While enable_i=0, no event, flag set or unaddressed pulse occurs, and any partial count is discarded.
- R6: bus_reset_flag_o is set on detection and stays set until flag_clr_i is high at a clock edge. A clear in the same cycle as a detection loses: the flag stays set.
- R7: After a detected bus reset, unaddr_o pulses for one cycle SYNC_STAGES+1 edges after the first edge at which the pins show a non-SE0 state.
- R8: During and right after reset (rst_ni=0), all outputs are low, even if the pins show SE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Detector clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Positive data line, asynchronous |
| dn_i | input | 1 | Negative data line, asynchronous |
| enable_i | input | 1 | Module enable; 0 disables detection |
| route_irq_i | input | 1 | 0: event goes to chip reset, 1: event goes to interrupt |
| flag_clr_i | input | 1 | Clear strobe for the sticky flag |
| chip_rst_req_o | output | 1 | One-cycle chip reset request |
| irq_o | output | 1 | One-cycle interrupt request |
| bus_reset_flag_o | output | 1 | Sticky bus reset seen flag |
| unaddr_o | output | 1 | One-cycle pulse to return to the unaddressed state |

## Verification
The bench builds the block with SYNC_STAGES=2 and SE0_CYCLES=12, so each episode fits in a few dozen cycles. With these values, random SE0 run lengths from zero to well past twice the threshold cover both sides of the boundary. The exact lengths 12 and 13 are also driven directly. The short threshold lets a single glitch split two near-threshold runs, lets a clear strobe land exactly on the detection edge, and gives the unaddressed pulse room to appear at its fixed offset after the lines go idle.

// File: rtl/usb_rst_pkg.sv
package usb_rst_pkg;

  // {dp, dn}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  typedef enum logic {
    ROUTE_CHIP_RST = 1'b0,
    ROUTE_IRQ      = 1'b1
  } route_e;

  function automatic logic is_se0(logic [1:0] lines);
    return line_state_e'(lines) == LS_SE0;
  endfunction

endpackage

// File: rtl/usb_rst_sync.sv
module usb_rst_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/usb_rst_se0_timer.sv
module usb_rst_se0_timer #(
  parameter int unsigned SE0_CYCLES = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic se0_i,
  output logic expired_o
);

  // saturating at SAT makes the expiry fire once per episode
  localparam int unsigned SAT = SE0_CYCLES + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (!en_i || !se0_i) begin
      run_q <= '0;
    end else if (run_q != CW'(SAT)) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign expired_o = en_i && se0_i && (run_q == CW'(SE0_CYCLES));

endmodule

// File: rtl/usb_rst_event.sv
module usb_rst_event
  import usb_rst_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   se0_i,
  input  logic   fire_i,
  input  route_e route_i,
  input  logic   clr_i,
  output logic   chip_rst_o,
  output logic   irq_o,
  output logic   flag_o,
  output logic   unaddr_o
);

  logic in_bus_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_rst_o   <= 1'b0;
      irq_o        <= 1'b0;
      flag_o       <= 1'b0;
      unaddr_o     <= 1'b0;
      in_bus_rst_q <= 1'b0;
    end else begin
      chip_rst_o <= fire_i && (route_i == ROUTE_CHIP_RST);
      irq_o      <= fire_i && (route_i == ROUTE_IRQ);
      // set beats clear
      if (fire_i)     flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
      unaddr_o <= en_i && in_bus_rst_q && !se0_i;
      if (!en_i || !se0_i) in_bus_rst_q <= 1'b0;
      else if (fire_i)     in_bus_rst_q <= 1'b1;
    end
  end

endmodule

// File: rtl/usb_bus_reset_det.sv
module usb_bus_reset_det
  import usb_rst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SE0_CYCLES  = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dn_i,
  input  logic enable_i,
  input  logic route_irq_i,
  input  logic flag_clr_i,
  output logic chip_rst_req_o,
  output logic irq_o,
  output logic bus_reset_flag_o,
  output logic unaddr_o
);

  logic [1:0] lines_s;
  logic       se0_s;
  logic       fire;

  // reset to J so no false SE0 leaves reset
  usb_rst_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (2),
    .RST_VAL(2'(LS_J))
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dp_i, dn_i}),
    .q_o   (lines_s)
  );

  assign se0_s = is_se0(lines_s);

  usb_rst_se0_timer #(
    .SE0_CYCLES(SE0_CYCLES)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i),
    .se0_i    (se0_s),
    .expired_o(fire)
  );

  usb_rst_event u_event (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable_i),
    .se0_i     (se0_s),
    .fire_i    (fire),
    .route_i   (route_e'(route_irq_i)),
    .clr_i     (flag_clr_i),
    .chip_rst_o(chip_rst_req_o),
    .irq_o     (irq_o),
    .flag_o    (bus_reset_flag_o),
    .unaddr_o  (unaddr_o)
  );

endmodule

// File: rtl/usb_bus_reset_det_chk.sv
module usb_bus_reset_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dp_i,
  input logic dn_i,
  input logic enable_i,
  input logic route_irq_i,
  input logic flag_clr_i,
  input logic chip_rst_req_o,
  input logic irq_o,
  input logic bus_reset_flag_o,
  input logic unaddr_o
);

  // R3
  exclusive_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chip_rst_req_o, irq_o}));

  // R3
  irq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(route_irq_i));

  // R4
  single_rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_req_o |=> !chip_rst_req_o);

  // R4
  single_irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!chip_rst_req_o && !irq_o && !unaddr_o));

  // R6
  flag_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_rst_req_o || irq_o) |-> bus_reset_flag_o);

  // R6
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_flag_o && !flag_clr_i) |=> bus_reset_flag_o);

  // R7
  single_unaddr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unaddr_o |=> !unaddr_o);

endmodule

bind usb_bus_reset_det usb_bus_reset_det_chk u_chk (.*);

// File: tb/usb_bus_reset_det_tb.sv
module usb_bus_reset_det_tb;

  localparam int SYNC = 2;
  localparam int THR  = 12;
  localparam int LAT  = SYNC + THR + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b1, dn = 1'b0;
  logic en = 1'b1, route = 1'b0, clr = 1'b0;
  logic chip_rst, irq, flag, unaddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  usb_bus_reset_det #(
    .SYNC_STAGES(SYNC),
    .SE0_CYCLES (THR)
  ) u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .dp_i            (dp),
    .dn_i            (dn),
    .enable_i        (en),
    .route_irq_i     (route),
    .flag_clr_i      (clr),
    .chip_rst_req_o  (chip_rst),
    .irq_o           (irq),
    .bus_reset_flag_o(flag),
    .unaddr_o        (unaddr)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // run that counts: starts after the glitch edge g (0 = none)
  function automatic int run_start(int g);
    return (g == 0) ? 0 : g;
  endfunction

  function automatic bit exp_det(int len, int g, bit e);
    return e && ((len - run_start(g)) >= THR + 1);
  endfunction

  function automatic bit exp_event_at(int k, int len, int g, bit e);
    return exp_det(len, g, e) && (k == run_start(g) + LAT);
  endfunction

  function automatic bit exp_unaddr_at(int k, int len, int g, bit e);
    return exp_det(len, g, e) && (k == len + SYNC + 1);
  endfunction

  function automatic bit exp_flag(int len, int g, bit e, int clr_at);
    return exp_det(len, g, e) && !(clr_at > run_start(g) + LAT);
  endfunction

  task automatic drive_idle(int sel);
    case (sel)
      2:       begin dp = 1'b0; dn = 1'b1; end // K
      3:       begin dp = 1'b1; dn = 1'b1; end // SE1
      default: begin dp = 1'b1; dn = 1'b0; end // J
    endcase
  endtask

  // pins show SE0 at edges 1..len except edge g; called at a negedge
  task automatic episode(int len, int g, bit r, bit e, int idle_sel, int clr_at);
    int total;
    int lim;
    lim   = (len > run_start(g) + LAT) ? len : run_start(g) + LAT;
    total = lim + SYNC + 4;
    route = r;
    en    = e;
    clr   = (clr_at == 1);
    if (len >= 1 && g != 1) begin dp = 1'b0; dn = 1'b0; end
    else drive_idle(idle_sel);
    for (int k = 1; k <= total; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1 R3", "chip_rst_req_o", int'(chip_rst), int'(exp_event_at(k, len, g, e) && !r));
      chk("R1 R3", "irq_o", int'(irq), int'(exp_event_at(k, len, g, e) && r));
      chk("R7", "unaddr_o", int'(unaddr), int'(exp_unaddr_at(k, len, g, e)));
      if (k + 1 <= len && k + 1 != g) begin dp = 1'b0; dn = 1'b0; end
      else drive_idle(idle_sel);
      clr = (k + 1 == clr_at);
    end
    clr = 1'b0;
    chk("R6", "flag after episode", int'(flag), int'(exp_flag(len, g, e, clr_at)));
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    chk("R6", "flag after clear", int'(flag), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5E0_0C0D));
    // R8: SE0 on pins while in reset
    dp = 1'b0; dn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8", "chip_rst_req_o in reset", int'(chip_rst), 0);
    chk("R8", "irq_o in reset", int'(irq), 0);
    chk("R8", "flag in reset", int'(flag), 0);
    chk("R8", "unaddr_o in reset", int'(unaddr), 0);
    drive_idle(1);
    rst_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    chk("R8", "outputs after reset", int'({chip_rst, irq, flag, unaddr}), 0);

    // R1 R2 boundary runs
    episode(THR, 0, 1'b0, 1'b1, 1, 0);
    episode(THR + 1, 0, 1'b0, 1'b1, 1, 0);
    episode(THR + 1, 0, 1'b1, 1'b1, 2, 0);
    episode(0, 0, 1'b0, 1'b1, 3, 0);
    // R4 long episode, one pulse only
    episode(3 * THR, 0, 1'b1, 1'b1, 1, 0);
    // R2 glitch splits two short runs (J, K, SE1 all restart)
    for (int s = 1; s <= 3; s++) episode(2 * THR + 1, THR + 1, 1'b0, 1'b1, s, 0);
    // R2 glitch then a long enough second run
    episode(2 * THR + 2, THR, 1'b1, 1'b1, 2, 0);
    // R5 disabled
    episode(3 * THR, 0, 1'b0, 1'b0, 1, 0);
    episode(3 * THR, 0, 1'b1, 1'b0, 3, 0);
    // R6 clear before, at and after the detection edge
    episode(2 * THR, 0, 1'b0, 1'b1, 1, 3);
    episode(2 * THR, 0, 1'b0, 1'b1, 1, LAT);
    episode(2 * THR, 0, 1'b1, 1'b1, 1, LAT + 2);

    // random episodes
    for (int n = 0; n < 80; n++) begin
      int len;
      int g;
      len = $urandom_range(2 * THR + 4, 0);
      g   = (($urandom % 4) == 0 && len > 2) ? $urandom_range(len, 1) : 0;
      if (g != 0 && g - 1 >= THR + 1) g = 0;
      episode(len, g, 1'($urandom), (($urandom % 6) != 0), $urandom_range(3, 1),
              (($urandom % 3) == 0) ? $urandom_range(LAT + 4, 1) : 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule